// File: doc/BRIEF.md
# SDRAM Read Burst Data Sequencer

This block is the data-out side of a synchronous DRAM model. When a read strobe is sampled, it takes the start column and a snapshot of the configured CAS latency and burst length. After that latency it places one data word per clock on the data bus. The words come from consecutive columns of the open row, which is held in an internal row array. When the burst is over, the output enable falls and the bus is released to high impedance.

Fixed bursts of 1, 2, 4 or 8 words step through the columns in sequential order and wrap inside the aligned block that holds the start column. A full-page burst has no length of its own. It walks the whole row, wraps from the last column to column 0, and runs until a terminate input arrives or a newer read takes over the bus.

Top module: `sdram_read_seq`

## Requirements
- R1: After reset, dqOe is low, the data bus is released, and curCol reads 0.
- R2: A read sampled on clock edge T shows its first word while dqOe is high, in the cycle that follows edge T+L. L is the value on cfgCasLat: 2 or 3.
- R3: While dqOe is high, dq carries the row word of column curCol. For 10-bit column c, that word is the 16-bit value {~c[5:0], c}.
- R4: Fixed bursts use cfgBurst codes 0, 1, 2 and 3 for lengths 1, 2, 4 and 8. Each following word takes the next column. The column wraps within the aligned block of the burst length, so a length-4 burst starting at column 5 reads 5, 6, 7, 4.
- R5: A fixed burst gives exactly its length in words. dqOe then falls on the next edge unless another read launches on that edge.
- R6: With cfgBurst code 7 (full page), the column advances from 1023 to 0 and the burst continues. A terminate sampled high on an edge makes dqOe low after that edge, unless a read launches on that same edge.
- R7: A read issued during a burst lets the old burst keep driving until the new read's own latency has passed. From then on only the new read's words appear.
- R8: CAS latency and burst length are taken when the read is sampled. Changing cfgCasLat or cfgBurst afterwards does not change that burst.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rstN | input | 1 | Active-low synchronous reset |
| rdStrobe | input | 1 | Read command, sampled on the rising edge |
| startCol | input | 10 | First column of the burst |
| cfgCasLat | input | 2 | Programmed CAS latency (2 or 3) |
| cfgBurst | input | 3 | Programmed burst code (0..3 fixed, 7 full page) |
| terminate | input | 1 | Ends the burst in progress |
| dq | output | 16 | Read data, high impedance when not driving |
| dqOe | output | 1 | High while dq carries a burst word |
| curCol | output | 10 | Column of the word currently driven |

## Verification
Bursts are issued with both latencies. One start column sits in the middle of an aligned block and another at the top of the row, so a plain increment and a block wrap give different columns. A single-word burst and an eight-word burst check that the length counting is exact at both ends. A full-page burst that starts three columns below the end shows the wrap to zero, then a terminate ends it. A back-to-back read shows that the earlier burst stops at the right boundary. A configuration change made right after a read shows whether the settings were captured at issue.

// File: rtl/rdseq_pkg.sv
package rdseq_pkg;
  localparam int COL_W     = 10;
  localparam int DATA_W    = 16;
  localparam int CL_W      = 2;
  localparam int BL_W      = 3;
  localparam int MAX_CL    = 3;
  localparam int MAX_FIXED = 8;
  localparam int CNT_W     = $clog2(MAX_FIXED) + 1;
  localparam int COLS      = 1 << COL_W;
  localparam logic [BL_W-1:0] BL_FULL = 3'b111;

  typedef struct packed {
    logic             launch;
    logic             advance;
    logic             stop;
    logic [COL_W-1:0] launchCol;
    logic [COL_W-1:0] wrapMask;
  } seqStrobe_t;
endpackage

// File: rtl/rdseq_ctrl.sv
module rdseq_ctrl
  import rdseq_pkg::*;
(
  input  logic             clk,
  input  logic             rstN,
  input  logic             rdStrobe,
  input  logic [COL_W-1:0] startCol,
  input  logic [CL_W-1:0]  cfgCasLat,
  input  logic [BL_W-1:0]  cfgBurst,
  input  logic             terminate,
  output seqStrobe_t       strobes,
  output logic             active
);
  // command delay line, each slot carrying its own captured settings
  logic [MAX_CL-1:0] pv;
  logic [COL_W-1:0]  pcol [MAX_CL];
  logic [BL_W-1:0]   pbl  [MAX_CL];
  logic [CL_W-1:0]   pcl  [MAX_CL];

  always_ff @(posedge clk) begin
    if (!rstN) begin
      pv[0]   <= 1'b0;
      pcol[0] <= '0;
      pbl[0]  <= '0;
      pcl[0]  <= '0;
    end else begin
      pv[0]   <= rdStrobe;
      pcol[0] <= startCol;
      pbl[0]  <= cfgBurst;
      pcl[0]  <= cfgCasLat;
    end
  end

  for (genvar k = 1; k < MAX_CL; k++) begin : g_stage
    always_ff @(posedge clk) begin
      if (!rstN) begin
        pv[k]   <= 1'b0;
        pcol[k] <= '0;
        pbl[k]  <= '0;
        pcl[k]  <= '0;
      end else begin
        pv[k]   <= pv[k-1];
        pcol[k] <= pcol[k-1];
        pbl[k]  <= pbl[k-1];
        pcl[k]  <= pcl[k-1];
      end
    end
  end

  logic             launchNow;
  logic [COL_W-1:0] selCol;
  logic [BL_W-1:0]  selBl;

  // newest matching command wins (lowest stage index assigned last)
  always_comb begin
    launchNow = 1'b0;
    selCol    = '0;
    selBl     = '0;
    for (int k = MAX_CL - 1; k >= 1; k--) begin
      if (pv[k] && pcl[k] == CL_W'(k + 1)) begin
        launchNow = 1'b1;
        selCol    = pcol[k];
        selBl     = pbl[k];
      end
    end
  end

  function automatic logic [CNT_W-1:0] burstLenOf(input logic [BL_W-1:0] code);
    return CNT_W'(1) << code[1:0];
  endfunction

  logic [BL_W-1:0]  curBl;
  logic [CNT_W-1:0] beatCnt;
  logic             fullPage;
  logic             atEnd;

  assign fullPage = (curBl == BL_FULL);
  assign atEnd    = !fullPage && (beatCnt == burstLenOf(curBl));

  assign strobes.launch    = launchNow;
  assign strobes.launchCol = selCol;
  assign strobes.advance   = active && !launchNow && !terminate && !atEnd;
  assign strobes.stop      = active && !launchNow && (terminate || atEnd);
  assign strobes.wrapMask  = fullPage ? '1 : COL_W'(burstLenOf(curBl)) - COL_W'(1);

  always_ff @(posedge clk) begin
    if (!rstN) begin
      active  <= 1'b0;
      curBl   <= '0;
      beatCnt <= '0;
    end else if (launchNow) begin
      active  <= 1'b1;
      curBl   <= selBl;
      beatCnt <= CNT_W'(1);
    end else if (strobes.stop) begin
      active  <= 1'b0;
    end else if (strobes.advance && !fullPage) begin
      beatCnt <= beatCnt + CNT_W'(1);
    end
  end

  // R2: first word after the programmed latency
  p_first_cl2_r2: assert property (@(posedge clk) disable iff (!rstN)
    (rdStrobe && cfgCasLat == CL_W'(2)) |-> ##3 active);
  p_first_cl3_r2: assert property (@(posedge clk) disable iff (!rstN)
    (rdStrobe && cfgCasLat == CL_W'(3)) |-> ##4 active);
  // R6: terminate releases the bus
  p_term_stop_r6: assert property (@(posedge clk) disable iff (!rstN)
    (terminate && active && !launchNow) |=> !active);
  // R5: fixed burst never exceeds its length
  p_len_bound_r5: assert property (@(posedge clk) disable iff (!rstN)
    (active && !fullPage) |-> (beatCnt <= burstLenOf(curBl)));
endmodule

// File: rtl/rdseq_dpath.sv
module rdseq_dpath
  import rdseq_pkg::*;
(
  input  logic              clk,
  input  logic              rstN,
  input  seqStrobe_t        strobes,
  input  logic              oe,
  output logic [DATA_W-1:0] dq,
  output logic [COL_W-1:0]  curCol
);
  localparam int PAD_W = DATA_W - COL_W;

  logic [DATA_W-1:0] rowMem [COLS];
  logic [COL_W-1:0]  colQ;
  logic [COL_W-1:0]  colInc;

  // open-row contents, computed from the column index
  always_comb begin
    for (int c = 0; c < COLS; c++) begin
      rowMem[c] = {~PAD_W'(c), COL_W'(c)};
    end
  end

  assign colInc = colQ + COL_W'(1);

  always_ff @(posedge clk) begin
    if (!rstN) begin
      colQ <= '0;
    end else if (strobes.launch) begin
      colQ <= strobes.launchCol;
    end else if (strobes.advance) begin
      colQ <= (colQ & ~strobes.wrapMask) | (colInc & strobes.wrapMask);
    end
  end

  assign curCol = colQ;
  assign dq     = oe ? rowMem[colQ] : 'z;

  // R4: in-block step by one
  p_step_r4: assert property (@(posedge clk) disable iff (!rstN)
    (strobes.advance && !strobes.launch) |=>
      ((colQ & $past(strobes.wrapMask)) == (($past(colQ) + COL_W'(1)) & $past(strobes.wrapMask))));
  // R6: full-page wrap from last column to 0
  p_page_wrap_r6: assert property (@(posedge clk) disable iff (!rstN)
    (strobes.advance && !strobes.launch && &strobes.wrapMask && &colQ) |=> (colQ == '0));
endmodule

// File: rtl/sdram_read_seq.sv
module sdram_read_seq
  import rdseq_pkg::*;
(
  input  logic              clk,
  input  logic              rstN,
  input  logic              rdStrobe,
  input  logic [COL_W-1:0]  startCol,
  input  logic [CL_W-1:0]   cfgCasLat,
  input  logic [BL_W-1:0]   cfgBurst,
  input  logic              terminate,
  output logic [DATA_W-1:0] dq,
  output logic              dqOe,
  output logic [COL_W-1:0]  curCol
);
  seqStrobe_t strobes;
  logic       active;

  rdseq_ctrl u_ctrl (
    .clk       (clk),
    .rstN      (rstN),
    .rdStrobe  (rdStrobe),
    .startCol  (startCol),
    .cfgCasLat (cfgCasLat),
    .cfgBurst  (cfgBurst),
    .terminate (terminate),
    .strobes   (strobes),
    .active    (active)
  );

  rdseq_dpath u_dpath (
    .clk     (clk),
    .rstN    (rstN),
    .strobes (strobes),
    .oe      (active),
    .dq      (dq),
    .curCol  (curCol)
  );

  assign dqOe = active;
endmodule

// File: tb/sim_sdram_read_seq.sv
module sim_sdram_read_seq;
  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        rdStrobe = 1'b0;
  logic [9:0]  startCol = '0;
  logic [1:0]  cfgCasLat = 2'd2;
  logic [2:0]  cfgBurst = 3'd0;
  logic        terminate = 1'b0;
  logic [15:0] dq;
  logic        dqOe;
  logic [9:0]  curCol;

  sdram_read_seq u0 (
    .clk(clk), .rstN(rstN), .rdStrobe(rdStrobe), .startCol(startCol),
    .cfgCasLat(cfgCasLat), .cfgBurst(cfgBurst), .terminate(terminate),
    .dq(dq), .dqOe(dqOe), .curCol(curCol)
  );

  always #2 clk = ~clk;  // 250 MHz

  typedef struct {
    int    cyc;
    int    col;
    string tag;
  } expItem_t;

  expItem_t expQ[$];
  int  cyc = 0;
  int  checks = 0;
  int  errors = 0;
  bit  done = 1'b0;
  bit  monOn = 1'b0;

  always @(posedge clk) cyc++;

  function automatic logic [15:0] expData(input int c);
    logic [9:0] cc;
    cc = 10'(c);
    return {~cc[5:0], cc};
  endfunction

  function automatic int refCol(input int start, input int bl, input int i);
    int len;
    if (bl == 7) return (start + i) % 1024;
    len = 1 << bl;
    return (start & ~(len - 1)) | ((start + i) & (len - 1));
  endfunction

  task automatic check(input bit ok, input string tag, input string what,
                       input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s: actual %0h expected %0h (cycle %0d)", tag, what, act, exp, cyc);
    end
  endtask

  // monitor: compares each cycle against the scoreboard
  always @(negedge clk) begin
    if (monOn && !done) begin
      if (expQ.size() > 0 && expQ[0].cyc == cyc) begin
        expItem_t it;
        it = expQ.pop_front();
        check(dqOe === 1'b1, it.tag, "dqOe", int'(dqOe), 1);
        check(curCol === 10'(it.col), it.tag, "curCol", int'(curCol), it.col);
        check(dq === expData(it.col), "R3", "dq", int'(dq), int'(expData(it.col)));
      end else begin
        check(dqOe === 1'b0, (expQ.size() > 0) ? expQ[0].tag : "R5", "idle dqOe", int'(dqOe), 0);
      end
    end
  end

  // driver: issues a read and queues the words expected from it
  task automatic readBurst(input int col, input int cl, input int bl,
                           input int nWords, input string tag, output int issue);
    @(negedge clk);
    rdStrobe  = 1'b1;
    startCol  = 10'(col);
    cfgCasLat = 2'(cl);
    cfgBurst  = 3'(bl);
    issue = cyc + 1;
    for (int i = 0; i < nWords; i++) begin
      expItem_t it;
      it.cyc = issue + cl + i;
      it.col = refCol(col, bl, i);
      it.tag = tag;
      expQ.push_back(it);
    end
    @(negedge clk);
    rdStrobe = 1'b0;
  endtask

  task automatic drain();
    while (expQ.size() > 0) @(negedge clk);
    repeat (4) @(negedge clk);
  endtask

  always @(posedge clk) begin
    if (cyc > 5000 && !done) begin
      done = 1'b1;
      errors++;
      $display("FAIL watchdog: actual %0d cycles expected completion", cyc);
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    int iss;
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    // R1: reset state
    check(dqOe === 1'b0, "R1", "dqOe", int'(dqOe), 0);
    check(curCol === 10'd0, "R1", "curCol", int'(curCol), 0);
    monOn = 1'b1;

    // R2 R4 R5: CL2, length 4, mid-block start
    readBurst(5, 2, 2, 4, "R4", iss);
    drain();
    // R2 R4: CL3, length 8, wrap within block of 8
    readBurst(13, 3, 3, 8, "R2", iss);
    drain();
    // R5: single word
    readBurst(100, 2, 0, 1, "R5", iss);
    drain();
    // R4: length 2 at top of row
    readBurst(1023, 3, 1, 2, "R4", iss);
    drain();

    // R6: full page across the row end, then terminate
    readBurst(1021, 2, 7, 6, "R6", iss);
    while (cyc != iss + 2 + 5) @(negedge clk);
    terminate = 1'b1;
    @(negedge clk);
    terminate = 1'b0;
    drain();

    // R7: second read truncates the first
    readBurst(0, 2, 3, 3, "R7", iss);
    @(negedge clk);
    readBurst(40, 2, 2, 4, "R7", iss);
    drain();

    // R8: settings changed right after issue have no effect
    readBurst(20, 3, 2, 4, "R8", iss);
    cfgCasLat = 2'd2;
    cfgBurst  = 3'd0;
    drain();

    done = 1'b1;
    if (expQ.size() != 0) begin
      errors++;
      $display("FAIL scoreboard: actual %0d leftover expected 0", expQ.size());
    end
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule